// File: doc/BRIEF.md
# DBI Four-Wire Serial Command Engine

This block is a serial master for small display controllers that take 8-bit words over a clock/data link, with a separate data/command select line. The host gives it an opcode and a byte count, then pulses a start strobe. The engine selects the panel and shifts the opcode out with the select line low. For a write, it then shifts the parameter or pixel bytes out with the select line high. For a read, it clocks in reply bytes and hands them back one at a time on a valid strobe.

The engine uses three clock rates, each set by a half-period divider of the system clock. Setup traffic uses a moderate rate. Frame-memory writes and long writes use the fastest rate. Reads use a slow rate. The engine decides on its own whether an opcode is a read, using a fixed table. Two readout opcodes, identification and status, reach the panel with one dummy clock in front of the reply. For these the engine fetches one extra byte and shifts the reply back into byte alignment.

Top module: `dbi_spi_engine`

## Requirements
- R1: `spi_cs_n` falls once per transaction and stays low from before the first opcode bit until after the last byte. The opcode byte is shifted with `spi_dc` = 0. Write parameter bytes are shifted with `spi_dc` = 1.
- R2: Serial mode 0. `spi_sck` idles low. Bytes go out MSB first. `spi_miso` is sampled on the rising edge. `spi_mosi` and `spi_dc` do not change while `spi_sck` is high.
- R3: These opcodes are reads: 0x04, 0x06 to 0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1 and 0xA8. Every other opcode is a write. A read keeps `spi_dc` low for its whole length.
- R4: The opcode byte of a write is clocked at the setup half-period, max(div_set, div_fast). So are the parameter bytes of a write whose opcode is not 0x2C and whose length is at most SHORT_MAX.
- R5: Parameter bytes after opcode 0x2C, or of any write longer than SHORT_MAX, are clocked at the fast half-period, div_fast.
- R6: Every byte of a read, opcode included, is clocked at the read half-period, max(div_read, 2*div_fast). This keeps the read clock at no more than half the fastest rate.
- R7: For opcodes 0x04 and 0x09, len+1 reply bytes b[0..len] are clocked in. Result byte i is {b[i][6:0], b[i+1][7]}, so the panel's data bits come back without the dummy clock.
- R8: Other reads return exactly `len` bytes, as received and in order, each on a one-cycle `rd_valid` pulse.
- R9: Opcode 0x04 or 0x09 with a length other than 3 or 4 gives a one-cycle `err` pulse. No transfer takes place: `spi_cs_n` stays high and `busy` stays low.
- R10: A write with length 0 shifts the opcode byte alone.
- R11: After reset, `spi_cs_n` = 1, `spi_sck` = 0, and `busy`, `err`, `rd_valid` and `tx_take` are 0. A divider of 0 acts as 1.
- R12: `tx_take` pulses once for each write parameter byte and never during a read. The byte sent is the value on `tx_data` at the clock edge just before that pulse.
- R13: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transaction with `cmd` and `len` |
| cmd | input | 8 | Opcode |
| len | input | LEN_W | Parameter count (write) or reply count (read) |
| tx_data | input | 8 | Next parameter or pixel byte |
| tx_take | output | 1 | The current `tx_data` byte has been taken |
| div_fast | input | DIV_W | Fast half-period, in system clocks |
| div_set | input | DIV_W | Setup half-period, in system clocks |
| div_read | input | DIV_W | Requested read half-period, in system clocks |
| busy | output | 1 | Transaction in progress |
| err | output | 1 | Rejected transaction (bad readout length) |
| rd_data | output | 8 | Read result byte |
| rd_valid | output | 1 | `rd_data` is valid |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the panel |
| spi_miso | input | 1 | Serial data from the panel |
| spi_cs_n | output | 1 | Panel select, active low |
| spi_dc | output | 1 | Data/command select, low for opcodes |

## Verification
The embedded assertions check, on every cycle:
- `spi_sck` is idle low whenever the panel is deselected.
- `spi_mosi` and `spi_dc` hold steady through each high phase of `spi_sck`.
- Read strobes come only inside a transaction, with `spi_dc` low.
- Taken parameter bytes come only with `spi_dc` high.
- A rejected request never opens a transaction.

Only the bench scenarios can show the rest: the half-period chosen for each byte class across a sweep of divider settings, the read/write classification of all 256 opcodes, the realignment of dummy-clocked replies, and the exact byte counts per transaction.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

    localparam logic [7:0] OP_GET_ID     = 8'h04;
    localparam logic [7:0] OP_GET_STATUS = 8'h09;
    localparam logic [7:0] OP_MEM_WRITE  = 8'h2C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_PAR,
        ST_RD,
        ST_FIN
    } eng_state_t;

    typedef enum logic [1:0] {
        RATE_SET,
        RATE_FAST,
        RATE_READ
    } rate_t;

    typedef struct packed {
        logic [7:0] op;
        logic       rd;
        logic       realign;
        logic       fast_par;
    } txn_flags_t;

    // Opcodes that return data from the panel
    function automatic logic is_read_op(input logic [7:0] op);
        logic r;
        case (op)
            8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B,
            8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45,
            8'h52, 8'h54, 8'h56, 8'h5F, 8'hA1, 8'hA8: r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    // Replies that arrive one clock late
    function automatic logic needs_realign(input logic [7:0] op);
        return (op == OP_GET_ID) || (op == OP_GET_STATUS);
    endfunction

    function automatic logic [7:0] join_shifted(input logic [7:0] prev,
                                                input logic [7:0] cur);
        return {prev[6:0], cur[7]};
    endfunction

endpackage

// File: rtl/dbi_rate_sel.sv
module dbi_rate_sel
    import dbi_pkg::*;
#(
    parameter int DIV_W = 8,
    localparam int HW   = DIV_W + 1
) (
    input  logic [DIV_W-1:0] div_fast,
    input  logic [DIV_W-1:0] div_set,
    input  logic [DIV_W-1:0] div_read,
    input  rate_t            sel,
    output logic [HW-1:0]    half
);
    logic [HW-1:0] h_fast, h_set_raw, h_rd_raw, h_set, h_rd, h_fast2;

    always_comb begin
        h_fast    = (div_fast == '0) ? HW'(1) : {1'b0, div_fast};
        h_set_raw = (div_set  == '0) ? HW'(1) : {1'b0, div_set};
        h_rd_raw  = (div_read == '0) ? HW'(1) : {1'b0, div_read};
        h_fast2   = h_fast << 1;
        h_set     = (h_set_raw > h_fast) ? h_set_raw : h_fast;
        h_rd      = (h_rd_raw > h_fast2) ? h_rd_raw : h_fast2;
        case (sel)
            RATE_FAST: half = h_fast;
            RATE_READ: half = h_rd;
            default:   half = h_set;
        endcase
    end
endmodule

// File: rtl/dbi_shifter.sv
module dbi_shifter #(
    parameter int HW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [HW-1:0] half,
    input  logic [7:0]    tx_byte,
    input  logic          miso,
    output logic          sck,
    output logic          mosi,
    output logic          done,
    output logic [7:0]    rx_byte
);
    logic          active;
    logic [HW-1:0] hcnt;
    logic [HW-1:0] half_q;
    logic [2:0]    bitn;
    logic [7:0]    tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            sck     <= 1'b0;
            done    <= 1'b0;
            hcnt    <= '0;
            half_q  <= HW'(1);
            bitn    <= '0;
            tx_sh   <= '0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active <= 1'b1;
                sck    <= 1'b0;
                hcnt   <= '0;
                bitn   <= '0;
                tx_sh  <= tx_byte;
                half_q <= half;
            end else if (active) begin
                if (hcnt == half_q - HW'(1)) begin
                    hcnt <= '0;
                    if (!sck) begin
                        sck     <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bitn == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bitn  <= bitn + 3'd1;
                            tx_sh <= {tx_sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    hcnt <= hcnt + HW'(1);
                end
            end
        end
    end

    assign mosi = tx_sh[7];

    // R2
    sck_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
        sck |-> active);
endmodule

// File: rtl/dbi_realign.sv
module dbi_realign
    import dbi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       begin_txn,
    input  logic       shift_mode,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte
);
    logic       have_prev;
    logic [7:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev <= 1'b0;
            prev      <= '0;
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (begin_txn) begin
                have_prev <= 1'b0;
            end else if (in_valid) begin
                if (shift_mode) begin
                    prev      <= in_byte;
                    have_prev <= 1'b1;
                    if (have_prev) begin
                        out_byte  <= join_shifted(prev, in_byte);
                        out_valid <= 1'b1;
                    end
                end else begin
                    out_byte  <= in_byte;
                    out_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dbi_spi_engine.sv
module dbi_spi_engine
    import dbi_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int DIV_W     = 8,
    parameter int SHORT_MAX = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       cmd,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       tx_data,
    output logic             tx_take,
    input  logic [DIV_W-1:0] div_fast,
    input  logic [DIV_W-1:0] div_set,
    input  logic [DIV_W-1:0] div_read,
    output logic             busy,
    output logic             err,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n,
    output logic             spi_dc
);
    localparam int HW    = DIV_W + 1;
    localparam int CNT_W = LEN_W + 1;

    eng_state_t       state;
    txn_flags_t       flags;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] rd_total;
    logic [7:0]       byte_q;
    rate_t            rsel;
    logic             go;
    logic             rl_begin;
    logic [HW-1:0]    half;
    logic             sh_done;
    logic [7:0]       sh_rx;
    logic             len_ok;
    logic             start_rd;

    assign len_ok   = (len == LEN_W'(3)) || (len == LEN_W'(4));
    assign start_rd = is_read_op(cmd);
    assign rd_total = {1'b0, len_q} + CNT_W'(flags.realign);
    assign busy     = (state != ST_IDLE);

    dbi_rate_sel #(.DIV_W(DIV_W)) u_rate (
        .div_fast (div_fast),
        .div_set  (div_set),
        .div_read (div_read),
        .sel      (rsel),
        .half     (half)
    );

    dbi_shifter #(.HW(HW)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .half    (half),
        .tx_byte (byte_q),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    dbi_realign u_align (
        .clk        (clk),
        .rst        (rst),
        .begin_txn  (rl_begin),
        .shift_mode (flags.realign),
        .in_valid   (sh_done && (state == ST_RD)),
        .in_byte    (sh_rx),
        .out_valid  (rd_valid),
        .out_byte   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            flags    <= '0;
            len_q    <= '0;
            rem      <= '0;
            byte_q   <= '0;
            rsel     <= RATE_SET;
            go       <= 1'b0;
            tx_take  <= 1'b0;
            err      <= 1'b0;
            rl_begin <= 1'b0;
            spi_cs_n <= 1'b1;
            spi_dc   <= 1'b0;
        end else begin
            go       <= 1'b0;
            tx_take  <= 1'b0;
            err      <= 1'b0;
            rl_begin <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    if (needs_realign(cmd) && !len_ok) begin
                        err <= 1'b1;
                    end else begin
                        flags.op       <= cmd;
                        flags.rd       <= start_rd;
                        flags.realign  <= start_rd && needs_realign(cmd);
                        flags.fast_par <= (cmd == OP_MEM_WRITE) || (32'(len) > SHORT_MAX);
                        len_q    <= len;
                        spi_cs_n <= 1'b0;
                        spi_dc   <= 1'b0;
                        byte_q   <= cmd;
                        rsel     <= start_rd ? RATE_READ : RATE_SET;
                        go       <= 1'b1;
                        rl_begin <= 1'b1;
                        state    <= ST_CMD;
                    end
                end
                ST_CMD: if (sh_done) begin
                    if (flags.rd) begin
                        if (rd_total == '0) begin
                            state <= ST_FIN;
                        end else begin
                            rem    <= rd_total;
                            byte_q <= '0;
                            go     <= 1'b1;
                            state  <= ST_RD;
                        end
                    end else if (len_q == '0) begin
                        state <= ST_FIN;
                    end else begin
                        rem     <= {1'b0, len_q};
                        spi_dc  <= 1'b1;
                        byte_q  <= tx_data;
                        tx_take <= 1'b1;
                        rsel    <= flags.fast_par ? RATE_FAST : RATE_SET;
                        go      <= 1'b1;
                        state   <= ST_PAR;
                    end
                end
                ST_PAR: if (sh_done) begin
                    if (rem == CNT_W'(1)) begin
                        state <= ST_FIN;
                    end else begin
                        rem     <= rem - CNT_W'(1);
                        byte_q  <= tx_data;
                        tx_take <= 1'b1;
                        go      <= 1'b1;
                    end
                end
                ST_RD: if (sh_done) begin
                    if (rem == CNT_W'(1)) begin
                        state <= ST_FIN;
                    end else begin
                        rem    <= rem - CNT_W'(1);
                        byte_q <= '0;
                        go     <= 1'b1;
                    end
                end
                default: begin
                    spi_cs_n <= 1'b1;
                    spi_dc   <= 1'b0;
                    state    <= ST_IDLE;
                end
            endcase
        end
    end

    // R2
    idle_sck_low_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        spi_sck |-> $stable(spi_mosi));

    // R2
    dc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        spi_sck |-> $stable(spi_dc));

    // R8
    rd_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (busy && !spi_dc));

    // R12
    take_with_data_chk: assert property (@(posedge clk) disable iff (rst)
        tx_take |-> (spi_dc && !spi_cs_n));

    // R9
    reject_no_txn_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && spi_cs_n));
endmodule

// File: tb/tb_dbi_spi_engine.sv
module tb_dbi_spi_engine;
    localparam int LEN_W = 8;
    localparam int DIV_W = 4;
    localparam int SHORT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] cmd = '0;
    logic [LEN_W-1:0] len = '0;
    logic [7:0] tx_data;
    logic tx_take;
    logic [DIV_W-1:0] div_fast = 4'd1, div_set = 4'd1, div_read = 4'd1;
    logic busy, err, rd_valid, spi_sck, spi_mosi, spi_cs_n, spi_dc;
    logic [7:0] rd_data;
    logic spi_miso = 1'b0;

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // slave / monitor state
    int takes = 0, nrd = 0, nbytes = 0, bitcnt = 0, cs_falls = 0, bad_cs = 0, err_cnt = 0, hi = 0;
    logic cs_prev = 1'b1, sck_prev = 1'b0;
    logic [7:0] shreg = '0;
    logic [7:0] cap_byte [0:15];
    logic       cap_dc   [0:15];
    int         cap_half [0:15];
    logic [7:0] rd_buf   [0:255];
    logic [7:0] resp     [0:7];
    bit dummy_mode = 0;

    // base values at the start of a transaction
    int base_take, base_rd, falls0, errs0;

    assign tx_data = 8'(takes * 37 + 17);

    dbi_spi_engine #(.LEN_W(LEN_W), .DIV_W(DIV_W), .SHORT_MAX(SHORT)) dut (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .len(len),
        .tx_data(tx_data), .tx_take(tx_take),
        .div_fast(div_fast), .div_set(div_set), .div_read(div_read),
        .busy(busy), .err(err), .rd_data(rd_data), .rd_valid(rd_valid),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .spi_dc(spi_dc)
    );

    function automatic logic miso_bit(input int k);
        int j;
        if (k < 8) return 1'b0;
        j = k - 8;
        if (dummy_mode) begin
            if (j == 0) return 1'b0;
            j = j - 1;
        end
        if (j / 8 < 8) return resp[j / 8][7 - (j % 8)];
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (cs_prev && !spi_cs_n) begin
                bitcnt = 0;
                nbytes = 0;
                cs_falls++;
            end
            if (spi_sck && !sck_prev) begin
                if (spi_cs_n) bad_cs++;
                shreg = {shreg[6:0], spi_mosi};
                hi = 1;
                bitcnt++;
                if (bitcnt % 8 == 0) begin
                    if (nbytes < 16) begin
                        cap_byte[nbytes] = shreg;
                        cap_dc[nbytes]   = spi_dc;
                    end
                    nbytes++;
                end
            end else if (spi_sck) begin
                hi++;
            end
            if (!spi_sck && sck_prev && (bitcnt % 8 == 1) && nbytes < 16)
                cap_half[nbytes] = hi;
            if (rd_valid) begin
                rd_buf[nrd & 255] = rd_data;
                nrd++;
            end
            if (tx_take) takes++;
            if (err) err_cnt++;
            cs_prev  = spi_cs_n;
            sck_prev = spi_sck;
            spi_miso = miso_bit(bitcnt);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit bench_is_rd(input logic [7:0] c);
        return c inside {8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C,
                         8'h0D, 8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54,
                         8'h56, 8'h5F, 8'hA1, 8'hA8};
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int eff_fast(); return mx(int'(div_fast), 1); endfunction
    function automatic int eff_set();  return mx(mx(int'(div_set), 1), eff_fast()); endfunction
    function automatic int eff_read(); return mx(mx(int'(div_read), 1), 2 * eff_fast()); endfunction

    task automatic start_txn(input logic [7:0] c, input int n);
        base_take  = takes;
        base_rd    = nrd;
        falls0     = cs_falls;
        errs0      = err_cnt;
        dummy_mode = (c == 8'h04) || (c == 8'h09);
        for (int i = 0; i < 8; i++) resp[i] = 8'(8'h96 ^ (i * 8'h4D) ^ c);
        cmd   = c;
        len   = LEN_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_txn();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input logic [7:0] c, input int n);
        start_txn(c, n);
        wait_txn();
    endtask

    task automatic check_txn(input logic [7:0] c, input int n, input int hc, input int hp);
        bit rd;
        bit dm;
        int expb;
        rd   = bench_is_rd(c);
        dm   = (c == 8'h04) || (c == 8'h09);
        expb = 1 + n + (dm ? 1 : 0);
        chk(cs_falls - falls0 == 1, "R1 one select window", cs_falls - falls0, 1);
        chk(bad_cs == 0, "R1 clock while deselected", bad_cs, 0);
        chk(nbytes == expb, "R1 byte count", nbytes, expb);
        chk(cap_byte[0] == c, "R2 opcode bits MSB first", int'(cap_byte[0]), int'(c));
        chk(cap_dc[0] == 1'b0, "R1 dc low for opcode", int'(cap_dc[0]), 0);
        chk(cap_half[0] == hc, rd ? "R6 read rate opcode" : "R4 setup rate opcode", cap_half[0], hc);
        for (int i = 1; i < expb && i < 16; i++) begin
            chk(cap_dc[i] == !rd, rd ? "R3 dc low in read" : "R1 dc high for data",
                int'(cap_dc[i]), rd ? 0 : 1);
            chk(cap_half[i] == hp, rd ? "R6 read rate" : "R4/R5 data rate", cap_half[i], hp);
            if (!rd)
                chk(cap_byte[i] == 8'((base_take + i - 1) * 37 + 17), "R12 data byte",
                    int'(cap_byte[i]), int'(8'((base_take + i - 1) * 37 + 17)));
        end
        chk(takes - base_take == (rd ? 0 : n), "R12 take count", takes - base_take, rd ? 0 : n);
        chk(nrd - base_rd == (rd ? n : 0), "R8 read strobe count", nrd - base_rd, rd ? n : 0);
        if (rd)
            for (int i = 0; i < n; i++)
                chk(rd_buf[(base_rd + i) & 255] == resp[i], dm ? "R7 realigned byte" : "R8 read byte",
                    int'(rd_buf[(base_rd + i) & 255]), int'(resp[i]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(spi_cs_n == 1'b1, "R11 cs_n after reset", int'(spi_cs_n), 1);
        chk(spi_sck == 1'b0, "R11 sck after reset", int'(spi_sck), 0);
        chk(busy == 1'b0, "R11 busy after reset", int'(busy), 0);
        chk(err == 1'b0, "R11 err after reset", int'(err), 0);
        chk(rd_valid == 1'b0, "R11 rd_valid after reset", int'(rd_valid), 0);
        chk(tx_take == 1'b0, "R11 tx_take after reset", int'(tx_take), 0);

        // Rate sweep: R4, R5, R6, R11
        for (int f = 1; f <= 2; f++)
            for (int s = 0; s <= 3; s++)
                for (int r = 0; r <= 4; r++) begin
                    div_fast = DIV_W'(f);
                    div_set  = DIV_W'(s);
                    div_read = DIV_W'(r);
                    run(8'h2A, 3);
                    check_txn(8'h2A, 3, eff_set(), eff_set());
                    if (s == 0)
                        chk(cap_half[0] == mx(1, f), "R11 zero divider", cap_half[0], mx(1, f));
                    run(8'h2C, 2);
                    check_txn(8'h2C, 2, eff_set(), eff_fast());
                    run(8'h0A, 2);
                    check_txn(8'h0A, 2, eff_read(), eff_read());
                end

        div_fast = 4'd1; div_set = 4'd3; div_read = 4'd2;
        // R5 long write goes fast, R4 boundary length stays at setup rate
        run(8'h33, SHORT + 2);
        check_txn(8'h33, SHORT + 2, 3, 1);
        run(8'h33, SHORT);
        check_txn(8'h33, SHORT, 3, 3);

        // R10 zero-length write
        run(8'h11, 0);
        check_txn(8'h11, 0, 3, 3);
        chk(nbytes == 1, "R10 opcode only", nbytes, 1);

        // R7 dummy-clocked replies
        run(8'h04, 3);
        check_txn(8'h04, 3, 2, 2);
        run(8'h09, 4);
        check_txn(8'h09, 4, 2, 2);
        run(8'h04, 4);
        check_txn(8'h04, 4, 2, 2);

        // R9 rejected lengths
        foreach (resp[k]) resp[k] = resp[k];
        for (int t = 0; t < 3; t++) begin
            logic [7:0] c;
            int n;
            c = (t == 1) ? 8'h09 : 8'h04;
            n = (t == 0) ? 2 : ((t == 1) ? 5 : 0);
            run(c, n);
            chk(err_cnt - errs0 == 1, "R9 err pulse", err_cnt - errs0, 1);
            chk(cs_falls == falls0, "R9 no select", cs_falls - falls0, 0);
        end

        // R13 start ignored while busy
        start_txn(8'h2A, 2);
        repeat (10) @(negedge clk);
        cmd = 8'h2C; len = LEN_W'(5); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_txn();
        chk(cs_falls - falls0 == 1, "R13 single transaction", cs_falls - falls0, 1);
        chk(nbytes == 3, "R13 byte count unchanged", nbytes, 3);
        chk(cap_byte[0] == 8'h2A, "R13 first opcode kept", int'(cap_byte[0]), 'h2A);

        // R3 classification sweep over every opcode
        div_fast = 4'd1; div_set = 4'd1; div_read = 4'd1;
        for (int c = 0; c < 256; c++) begin
            run(8'(c), 1);
            if (c == 'h04 || c == 'h09) begin
                chk(err_cnt - errs0 == 1, "R9 short readout", err_cnt - errs0, 1);
                chk(cs_falls == falls0, "R9 no select", cs_falls - falls0, 0);
            end else begin
                check_txn(8'(c), 1, bench_is_rd(8'(c)) ? 2 : 1, bench_is_rd(8'(c)) ? 2 : 1);
                chk(nrd - base_rd == (bench_is_rd(8'(c)) ? 1 : 0), "R3 classification",
                    nrd - base_rd, bench_is_rd(8'(c)) ? 1 : 0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule